// File: doc/BRIEF.md
# Split-Mode Performance Counter Bank

This block holds four 32-bit event counters that software reaches through a 64-bit register bus. A per-counter size bit in the control register lets each physical counter run as one 32-bit counter or as two independent 16-bit counters. The bank therefore offers eight logical counters, each driven by its own event input.

Software writes to a counter do not disturb the running count. Each write lands in a holding latch and raises a pending flag for that physical counter. A control-register write that carries the global enable bit as 1 copies every pending latch into its live counter. This covers both turning the monitor on and rewriting the control register while the monitor is already on. Clearing the enable bit freezes all counts in place.

Each logical counter has a sticky overflow flag in the status register. The flag is set when the counter wraps and is cleared by writing a 1 to it.

Top module: `perf_ctr_bank`

## Requirements
- R1: Register values travel in bus bits [63:32]. Bits [31:0] of a write are ignored, and bits [31:0] of read data are always zero. Read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is sampled high, and it holds until the next read.
- R2: After synchronous reset, the control register, the status register, every live counter, every latch and every pending flag read as zero. All counters are in 32-bit mode and the monitor is disabled.
- R3: The address map is as follows.
  - Address 0 is the control register: bit 31 is the global enable, and bits [3:0] are the size bits of physical counters 3..0. All other control bits read as zero.
  - Address 1 is the status register.
  - Address 8+i is logical counter i, for i = 0..7.
- R4: A write to a counter register loads only that physical counter's latch and sets its pending flag. The live counter is unchanged. While the flag is set, a read of the counter returns the latch contents.
- R5: A control-register write with bit 31 = 1 copies each pending latch into its live counter and clears all pending flags. After that, reads return the live count.
- R6: Live counters advance only while the enable bit is 1. While it is 0, counter values do not change under event pulses.
- R7: With a size bit of 0, physical counter n is one 32-bit counter. It counts pulses on `evt[n]`, and `evt[n+4]` has no effect on it. Logical counters n and n+4 both read and write the full 32-bit value.
- R8: With a size bit of 1, logical counter n is bits [31:16] of physical counter n, and logical counter n+4 is bits [15:0]. A write through one logical counter keeps the other half's current value. A read returns the half zero-extended.
- R9: In 16-bit mode the upper half counts `evt[n]` and the lower half counts `evt[n+4]`. Each half wraps from 0xFFFF to 0 without carrying into the other half.
- R10: Status bit i is set when logical counter i wraps while the monitor is enabled; a 32-bit counter n wraps into bit n. Writing 1 to a status bit clears it, writing 0 leaves it alone, and a wrap in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 64 | Write data, register in bits [63:32] |
| bus_rdata | output | 64 | Registered read data, register in bits [63:32] |
| evt | input | 8 | One event pulse input per logical counter |

## Verification
The hardest situation to reach is a pending latch that differs from a live counter that keeps advancing underneath it. The read path shows only the latch in that state, so the hidden live count is exposed only after the next commit or by the lack of change across events. The stimulus writes a counter while the monitor runs, pulses events, reads the latch value back, and then rewrites the control register. A 16-bit half is preloaded to 0xFFFF or 0xFFFE through two staged half-writes and one commit, so that single event pulses drive each half across its wrap and the no-carry and sticky-flag behaviour can be seen.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;
  localparam int BUS_W  = 64;
  localparam int REG_W  = 32;
  localparam int EN_BIT = 31;
  localparam int ADR_CTRL = 0;
  localparam int ADR_STAT = 1;
endpackage

// File: rtl/perf_ctr_slice.sv
module perf_ctr_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         split,
  input  logic         run,
  input  logic         commit,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wdata,
  input  logic         evt_hi,
  input  logic         evt_lo,
  output logic [W-1:0] view,
  output logic [W-1:0] live,
  output logic         pend,
  output logic         wrap_hi,
  output logic         wrap_lo
);
  localparam int H = W / 2;

  logic [W-1:0] latch_q, live_q, cnt_next, latch_next;
  logic         pend_q, load, hi_max, lo_max;

  assign view   = pend_q ? latch_q : live_q;
  assign live   = live_q;
  assign pend   = pend_q;
  assign load   = commit & pend_q;
  assign hi_max = &live_q[W-1:H];
  assign lo_max = &live_q[H-1:0];

  always_comb begin
    wrap_hi = run & ~load & evt_hi & (split ? hi_max : (hi_max & lo_max));
    wrap_lo = run & ~load & split & evt_lo & lo_max;
  end

  always_comb begin
    if (split) begin
      cnt_next[W-1:H] = live_q[W-1:H] + {{(H-1){1'b0}}, evt_hi};
      cnt_next[H-1:0] = live_q[H-1:0] + {{(H-1){1'b0}}, evt_lo};
    end else begin
      cnt_next = live_q + {{(W-1){1'b0}}, evt_hi};
    end
  end

  always_comb begin
    if (!split)     latch_next = wdata;
    else if (wr_hi) latch_next = {wdata[H-1:0], view[H-1:0]};
    else            latch_next = {view[W-1:H], wdata[H-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      live_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_hi | wr_lo) begin
        latch_q <= latch_next;
        pend_q  <= 1'b1;
      end else if (load) begin
        pend_q  <= 1'b0;
      end
      if (load)     live_q <= latch_q;
      else if (run) live_q <= cnt_next;
    end
  end
endmodule

// File: rtl/perf_ctr_status.sv
module perf_ctr_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] sticky
);
  logic [N-1:0] clr;

  assign clr = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) sticky <= '0;
    else     sticky <= (sticky & ~clr) | set;
  end
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank #(
  parameter int NUM_PHYS = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [$clog2(2*NUM_PHYS):0]       bus_addr,
  input  logic [perf_ctr_pkg::BUS_W-1:0]    bus_wdata,
  output logic [perf_ctr_pkg::BUS_W-1:0]    bus_rdata,
  input  logic [2*NUM_PHYS-1:0]             evt
);
  import perf_ctr_pkg::*;

  localparam int NUM_LOG = 2 * NUM_PHYS;
  localparam int IDX_W   = $clog2(NUM_LOG);
  localparam int AW      = IDX_W + 1;
  localparam int PW      = IDX_W - 1;
  localparam int HW      = REG_W / 2;

  logic [REG_W-1:0]          wreg;
  logic                      en_q;
  logic [NUM_PHYS-1:0]       split_q;
  logic                      ctrl_we, stat_we, ctr_sel, commit;
  logic [IDX_W-1:0]          idx;
  logic [PW-1:0]             phys;
  logic [REG_W-1:0]          view_a [NUM_PHYS];
  logic [NUM_PHYS*REG_W-1:0] live_flat;
  logic [NUM_PHYS-1:0]       pend_v, wrap_h, wrap_l;
  logic [NUM_LOG-1:0]        sticky;
  logic [REG_W-1:0]          rd_word, cview;

  assign wreg    = bus_wdata[BUS_W-1:BUS_W-REG_W];
  assign ctrl_we = bus_wr && (bus_addr == AW'(ADR_CTRL));
  assign stat_we = bus_wr && (bus_addr == AW'(ADR_STAT));
  assign ctr_sel = bus_addr[IDX_W];
  assign idx     = bus_addr[IDX_W-1:0];
  assign phys    = idx[PW-1:0];
  assign commit  = ctrl_we & wreg[EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      split_q <= '0;
    end else if (ctrl_we) begin
      en_q    <= wreg[EN_BIT];
      split_q <= wreg[NUM_PHYS-1:0];
    end
  end

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_slice
    perf_ctr_slice #(.W(REG_W)) i_slice (
      .clk     (clk),
      .rst     (rst),
      .split   (split_q[g]),
      .run     (en_q),
      .commit  (commit),
      .wr_hi   (bus_wr && ctr_sel && (idx == IDX_W'(g))),
      .wr_lo   (bus_wr && ctr_sel && (idx == IDX_W'(g + NUM_PHYS))),
      .wdata   (wreg),
      .evt_hi  (evt[g]),
      .evt_lo  (evt[g+NUM_PHYS]),
      .view    (view_a[g]),
      .live    (live_flat[g*REG_W +: REG_W]),
      .pend    (pend_v[g]),
      .wrap_hi (wrap_h[g]),
      .wrap_lo (wrap_l[g])
    );
  end

  perf_ctr_status #(.N(NUM_LOG)) i_status (
    .clk      (clk),
    .rst      (rst),
    .set      ({wrap_l, wrap_h}),
    .clr_we   (stat_we),
    .clr_mask (wreg[NUM_LOG-1:0]),
    .sticky   (sticky)
  );

  always_comb begin
    cview = view_a[phys];
    if (split_q[phys]) begin
      if (idx[IDX_W-1]) cview = {{HW{1'b0}}, view_a[phys][HW-1:0]};
      else              cview = {{HW{1'b0}}, view_a[phys][REG_W-1:HW]};
    end
    rd_word = '0;
    if (ctr_sel) begin
      rd_word = cview;
    end else if (bus_addr == AW'(ADR_CTRL)) begin
      rd_word[EN_BIT]         = en_q;
      rd_word[NUM_PHYS-1:0]   = split_q;
    end else if (bus_addr == AW'(ADR_STAT)) begin
      rd_word[NUM_LOG-1:0]    = sticky;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {rd_word, {(BUS_W-REG_W){1'b0}}};
  end
endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk #(
  parameter int NUM_PHYS = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_wr,
  input logic [$clog2(2*NUM_PHYS):0] bus_addr,
  input logic                        wen_bit,
  input logic [31:0]                 rdata_lo,
  input logic                        en,
  input logic [2*NUM_PHYS-1:0]       sticky,
  input logic [NUM_PHYS-1:0]         pend,
  input logic [NUM_PHYS*32-1:0]      live_flat
);
  localparam int IDX_W = $clog2(2 * NUM_PHYS);

  AST_LOW_HALF_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata_lo == 32'h0); // R1

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!en && sticky == '0 && pend == '0 && live_flat == '0)); // R2

  AST_LATCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[IDX_W] && !en) |=> $stable(live_flat)); // R4

  AST_COMMIT_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == '0 && wen_bit) |=> (pend == '0)); // R5

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !bus_wr) |=> $stable(live_flat)); // R6

  AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 1) |=> ((sticky & $past(sticky)) == $past(sticky))); // R10
endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(.NUM_PHYS(NUM_PHYS)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .wen_bit   (bus_wdata[63]),
  .rdata_lo  (bus_rdata[31:0]),
  .en        (en_q),
  .sticky    (sticky),
  .pend      (pend_v),
  .live_flat (live_flat)
);

// File: tb/test_perf_ctr_bank.sv
`timescale 1ns/1ps
module test_perf_ctr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [7:0]  evt = '0;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  perf_ctr_bank i_perf_ctr_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt)
  );

  // op: 0 write, 1 read and compare, 2 event pulse (mask in data[7:0])
  localparam int NV = 36;
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 4'h8, 32'h0000_0010, 32'h0, 4'd4},   // R4 latch write while off
    {2'd1, 4'h8, 32'h0, 32'h0000_0010, 4'd4},   // R4 pending view
    {2'd2, 4'h0, 32'h0000_0001, 32'h0, 4'd6},
    {2'd0, 4'h0, 32'h8000_0000, 32'h0, 4'd5},   // R5 enable commits
    {2'd1, 4'h8, 32'h0, 32'h0000_0010, 4'd5},
    {2'd2, 4'h0, 32'h0000_0001, 32'h0, 4'd6},
    {2'd1, 4'h8, 32'h0, 32'h0000_0011, 4'd6},   // R6 counts when on
    {2'd0, 4'h8, 32'h0000_0100, 32'h0, 4'd4},
    {2'd2, 4'h0, 32'h0000_0001, 32'h0, 4'd4},
    {2'd1, 4'h8, 32'h0, 32'h0000_0100, 4'd4},   // R4 latch hides live
    {2'd0, 4'h0, 32'h8000_0000, 32'h0, 4'd5},   // R5 rewrite while on
    {2'd1, 4'h8, 32'h0, 32'h0000_0100, 4'd5},
    {2'd2, 4'h0, 32'h0000_0001, 32'h0, 4'd6},
    {2'd1, 4'h8, 32'h0, 32'h0000_0101, 4'd6},
    {2'd0, 4'h0, 32'h8000_0002, 32'h0, 4'd8},   // split counter 1
    {2'd0, 4'h9, 32'h0000_FFFF, 32'h0, 4'd8},
    {2'd0, 4'hD, 32'h0000_FFFE, 32'h0, 4'd8},
    {2'd1, 4'h9, 32'h0, 32'h0000_FFFF, 4'd8},   // R8 upper half kept
    {2'd1, 4'hD, 32'h0, 32'h0000_FFFE, 4'd8},   // R8 lower half
    {2'd0, 4'h0, 32'h8000_0002, 32'h0, 4'd5},
    {2'd2, 4'h0, 32'h0000_0022, 32'h0, 4'd9},
    {2'd1, 4'h9, 32'h0, 32'h0000_0000, 4'd9},   // R9 upper wraps
    {2'd1, 4'hD, 32'h0, 32'h0000_FFFF, 4'd9},   // R9 no carry in
    {2'd2, 4'h0, 32'h0000_0020, 32'h0, 4'd9},
    {2'd1, 4'h9, 32'h0, 32'h0000_0000, 4'd9},   // R9 no carry out
    {2'd1, 4'hD, 32'h0, 32'h0000_0000, 4'd9},
    {2'd1, 4'h1, 32'h0, 32'h0000_0022, 4'd10},  // R10 both halves flagged
    {2'd0, 4'h1, 32'h0000_0002, 32'h0, 4'd10},
    {2'd1, 4'h1, 32'h0, 32'h0000_0020, 4'd10},  // R10 write-1 clear
    {2'd2, 4'h0, 32'h0000_0010, 32'h0, 4'd7},
    {2'd1, 4'h8, 32'h0, 32'h0000_0101, 4'd7},   // R7 evt4 ignored
    {2'd1, 4'hC, 32'h0, 32'h0000_0101, 4'd7},   // R7 alias full width
    {2'd0, 4'h0, 32'h0000_0002, 32'h0, 4'd6},
    {2'd2, 4'h0, 32'h0000_0001, 32'h0, 4'd6},
    {2'd1, 4'h8, 32'h0, 32'h0000_0101, 4'd6},   // R6 frozen when off
    {2'd1, 4'h0, 32'h0, 32'h0000_0002, 4'd3}    // R3 control layout
  };

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    total++;
    if (bus_rdata !== {exp, 32'h0}) begin
      fails++;
      $display("FAIL %s addr %0h: got %h expected %h", req, a, bus_rdata, {exp, 32'h0});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    rd_chk(4'h0, 32'h0, "R2");
    rd_chk(4'h1, 32'h0, "R2");
    for (int i = 0; i < 8; i++) rd_chk(4'(8 + i), 32'h0, "R2");

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][73:72])
        2'd0: wr(VEC[v][71:68], {VEC[v][67:36], 32'h0});
        2'd1: rd_chk(VEC[v][71:68], VEC[v][35:4], $sformatf("R%0d", VEC[v][3:0]));
        default: pulse(VEC[v][43:36]);
      endcase
    end

    // R1 lower half of write ignored, read lower half zero
    wr(4'hB, {32'h0000_0005, 32'hFFFF_FFFF});
    rd_chk(4'hB, 32'h0000_0005, "R1");
    // R10 32-bit wrap sets bit n
    wr(4'hA, {32'hFFFF_FFFF, 32'h0});
    wr(4'h0, {32'h8000_0000, 32'h0});
    pulse(8'h04);
    rd_chk(4'hA, 32'h0, "R10");
    rd_chk(4'h1, 32'h0000_0024, "R10");
    // R3 unused control bits read zero
    wr(4'h0, {32'h7FFF_FFF0, 32'h0});
    rd_chk(4'h0, 32'h0, "R3");
    // R2 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_chk(4'h0, 32'h0, "R2");
    rd_chk(4'h1, 32'h0, "R2");
    rd_chk(4'hA, 32'h0, "R2");
    rd_chk(4'hB, 32'h0, "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule